// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block is the host side of a link to a serial digital-to-analog converter. A parallel word arrives over a valid/ready handshake. The block then sends it as one 16-bit frame, most significant bit first, on a serial clock, a frame line and a serial data line. The converter takes each bit on a falling clock edge. A separate active-low update strobe tells the converter to move the new code to its analog output.

The serial clock is derived from the system clock by counting cycles. Every pulse width and setup interval is a compile-time cycle count, which the integrator rounds up from the nanosecond minimums at the chosen clock rate. The static input `dsp_framing` selects the frame shape:

- **Controller framing** holds the frame line low for the whole frame.
- **DSP framing** first parks the serial clock low, then gives a short low pulse on the frame line that covers only the first data edge.

The parameter `AUTO_UPDATE` selects how the update strobe is produced. When it is 1, the strobe fires after every frame. When it is 0, the strobe fires only on request.

The controller moves through these states:

- IDLE
- PARK, serial clock low ahead of a DSP frame
- LEAD, frame line low ahead of the first fall
- CLK_LO and CLK_HI, the bit loop
- TAIL_LO, frame still open after the last fall
- TAIL_HI, frame closed with the clock still low
- UPDATE, strobe low

The transitions are:

- IDLE→UPDATE when a request is pending.
- IDLE→PARK on accept with DSP framing.
- IDLE→LEAD on accept with controller framing.
- PARK→LEAD, LEAD→CLK_LO, CLK_LO→CLK_HI and CLK_HI→CLK_LO, each on timer expiry.
- CLK_LO→TAIL_LO after the sixteenth low phase.
- TAIL_LO→TAIL_HI on timer expiry.
- TAIL_HI→UPDATE in auto mode, or TAIL_HI→IDLE in manual mode.
- UPDATE→IDLE on timer expiry.

Top module: `dac_frame_tx`

## Requirements
- R1: Out of reset and whenever idle: `ser_clk`=1, `frame_n`=1, `update_n`=1, `ser_data`=0, `busy`=0; `in_ready`=1 unless an update request is pending.
- R2: A word is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 whenever `busy` is 1, and `busy` is 1 from the cycle after acceptance.
- R3: A frame has exactly 16 falling edges of `ser_clk` while the frame is open. Taking `ser_data` at each of them yields the accepted word, bit 15 first. `ser_data` does not change while `ser_clk` stays low.
- R4: In the bit loop each `ser_clk` low and high phase lasts exactly SCLK_HALF_CYC cycles, so falls are 2·SCLK_HALF_CYC cycles apart.
- R5: Controller framing, with LEAD = max(SCLK_HALF_CYC, SETUP_CYC, FS_GAP_CYC):
  - `frame_n` falls with `ser_clk` high in the cycle after acceptance, and the first fall follows LEAD cycles later.
  - `frame_n` rises SCLK_HALF_CYC+FS_GAP_CYC cycles after the last fall, while `ser_clk` is still low.
  - `frame_n` then stays high.
- R6: DSP framing:
  - `ser_clk` is low for LEAD cycles before `frame_n` falls.
  - `frame_n` stays low for LEAD+SCLK_HALF_CYC cycles and rises with the first rising clock edge of the frame.
  - The first data fall comes 2·LEAD cycles after acceptance.
- R7: In both modes `ser_clk` rises again SCLK_HALF_CYC+2·FS_GAP_CYC cycles after the last fall.
- R8: With AUTO_UPDATE=1:
  - `update_n` goes low for exactly UPDATE_LOW_CYC cycles, starting on the cycle `ser_clk` returns high after a frame.
  - It goes low once per frame, with `frame_n` and `ser_clk` high.
  - `load_req` has no effect.
- R9: With AUTO_UPDATE=0:
  - No strobe follows a frame by itself.
  - A one-cycle `load_req` pulse gives one UPDATE_LOW_CYC-cycle low strobe, starting two cycles after the request edge. `in_ready` is held low while the request is pending.
  - A request raised during a frame is kept and served one cycle after the frame ends.
- R10: `busy` falls only with `frame_n` and `update_n` high. It falls when `ser_clk` returns high (manual mode) or when the strobe ends (auto mode), and `frame_n` is never low while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_framing | input | 1 | 0 = frame line low for whole frame, 1 = short frame pulse; change only while idle |
| in_valid | input | 1 | Word offered |
| in_data | input | WORD_W | Word to send |
| in_ready | output | 1 | Block can take a word |
| load_req | input | 1 | Update request (manual update mode only) |
| ser_clk | output | 1 | Serial clock to converter |
| frame_n | output | 1 | Active-low frame line |
| ser_data | output | 1 | Serial data, taken by the converter on falling `ser_clk` |
| update_n | output | 1 | Active-low analog update strobe |
| busy | output | 1 | Transfer or strobe in progress |

## Verification
The bench runs one directed task per scenario.

- **Frame bits.** It records the cycle of every clock fall taken while the frame line is low and checks the captured word. It uses a word with only the end bits set, so a design off by one in shift count or bit order misplaces the first or last bit.
- **Frame edges.** It measures where the frame line falls and rises relative to those falls in both framings. A design that lowers the frame line without parking the clock, or raises it on a clock rise, shows a wrong edge cycle.
- **Update strobe.** Update requests are issued while idle and in the middle of a frame. A design that drops a mid-frame request, strobes while the frame is open, or honours requests in auto mode gives the wrong pulse count or position.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PARK,
        S_LEAD,
        S_CLK_LO,
        S_CLK_HI,
        S_TAIL_LO,
        S_TAIL_HI,
        S_UPDATE
    } tx_state_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_tx_timer.sv
// Down-counter that times every state; done while the count is zero.
module dac_tx_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dac_tx_shifter.sv
// Holds the word being sent and tracks which bit is on the line.
module dac_tx_shifter #(
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              last_bit
);

    logic [WORD_W-1:0] sr_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= load_word;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb      = sr_q[WORD_W-1];
    assign bit_idx  = idx_q;
    assign last_bit = (idx_q == IDX_W'(WORD_W - 1));

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int WORD_W         = 16,
    parameter int SCLK_HALF_CYC  = 1,
    parameter int SETUP_CYC      = 1,
    parameter int FS_GAP_CYC     = 1,
    parameter int UPDATE_LOW_CYC = 1,
    parameter bit AUTO_UPDATE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_framing,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              load_req,
    output logic              ser_clk,
    output logic              frame_n,
    output logic              ser_data,
    output logic              update_n,
    output logic              busy
);

    localparam int LEAD_CYC = int'(max_u(max_u(SCLK_HALF_CYC, SETUP_CYC), FS_GAP_CYC));
    localparam int MAX_DUR  = int'(max_u(LEAD_CYC, UPDATE_LOW_CYC));
    localparam int CNT_W    = $clog2(MAX_DUR) + 1;
    localparam int IDX_W    = $clog2(WORD_W);

    tx_state_t        state_q, state_d;
    logic             t_done, t_load;
    logic [CNT_W-1:0] t_val;
    logic             accept, do_shift;
    logic             msb, last_bit;
    logic [IDX_W-1:0] bit_idx;
    logic             load_pend;

    assign accept   = in_valid && in_ready;
    assign do_shift = (state_q == S_CLK_LO) && t_done && !last_bit;

    // Cycles spent in each state, minus one, loaded on entry.
    function automatic logic [CNT_W-1:0] dur_m1(input tx_state_t s);
        unique case (s)
            S_PARK, S_LEAD:       return CNT_W'(LEAD_CYC - 1);
            S_CLK_LO, S_CLK_HI:   return CNT_W'(SCLK_HALF_CYC - 1);
            S_TAIL_LO, S_TAIL_HI: return CNT_W'(FS_GAP_CYC - 1);
            S_UPDATE:             return CNT_W'(UPDATE_LOW_CYC - 1);
            default:              return '0;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (load_pend) begin
                    state_d = S_UPDATE;
                end else if (in_valid) begin
                    state_d = dsp_framing ? S_PARK : S_LEAD;
                end
            end
            S_PARK:    if (t_done) state_d = S_LEAD;
            S_LEAD:    if (t_done) state_d = S_CLK_LO;
            S_CLK_LO:  if (t_done) state_d = last_bit ? S_TAIL_LO : S_CLK_HI;
            S_CLK_HI:  if (t_done) state_d = S_CLK_LO;
            S_TAIL_LO: if (t_done) state_d = S_TAIL_HI;
            S_TAIL_HI: if (t_done) state_d = AUTO_UPDATE ? S_UPDATE : S_IDLE;
            S_UPDATE:  if (t_done) state_d = S_IDLE;
        endcase
    end

    assign t_load = (state_d != state_q);
    assign t_val  = dur_m1(state_d);

    // Outputs decoded from the state
    always_comb begin
        ser_clk  = 1'b1;
        frame_n  = 1'b1;
        update_n = 1'b1;
        ser_data = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PARK: begin
                ser_clk  = 1'b0;
                ser_data = msb;
            end
            S_LEAD: begin
                frame_n  = 1'b0;
                ser_data = msb;
            end
            S_CLK_LO: begin
                ser_clk  = 1'b0;
                ser_data = msb;
                frame_n  = dsp_framing ? (bit_idx != '0) : 1'b0;
            end
            S_CLK_HI: begin
                ser_data = msb;
                frame_n  = dsp_framing;
            end
            S_TAIL_LO: begin
                ser_clk  = 1'b0;
                ser_data = msb;
                frame_n  = dsp_framing;
            end
            S_TAIL_HI: begin
                ser_clk  = 1'b0;
                ser_data = msb;
            end
            S_UPDATE: update_n = 1'b0;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign in_ready = (state_q == S_IDLE) && !load_pend;

    // Update request handling picked by the update mode
    generate
        if (AUTO_UPDATE) begin : g_auto
            logic unused_load_req;
            assign unused_load_req = load_req;
            assign load_pend       = 1'b0;
        end else begin : g_manual
            logic pend_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else if (load_req) begin
                    pend_q <= 1'b1;
                end else if (state_q == S_UPDATE && t_done) begin
                    pend_q <= 1'b0;
                end
            end
            assign load_pend = pend_q;
        end
    endgenerate

    dac_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    dac_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (in_data),
        .shift     (do_shift),
        .msb       (msb),
        .bit_idx   (bit_idx),
        .last_bit  (last_bit)
    );

endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic dsp_framing,
    input logic in_ready,
    input logic ser_clk,
    input logic frame_n,
    input logic ser_data,
    input logic update_n,
    input logic busy
);

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !busy);

    a_r3_data_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && $past(!ser_clk)) |-> $stable(ser_data));

    a_r5_frame_close_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_n) && !dsp_framing) |-> !ser_clk);

    a_r6_clk_parked_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && dsp_framing) |-> $past(!ser_clk));

    a_r8_strobe_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !update_n |-> (frame_n && ser_clk));

    a_r10_frame_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> busy);

    a_r10_busy_ends_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (frame_n && update_n));

endmodule

bind dac_frame_tx dac_frame_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dsp_framing (dsp_framing),
    .in_ready    (in_ready),
    .ser_clk     (ser_clk),
    .frame_n     (frame_n),
    .ser_data    (ser_data),
    .update_n    (update_n),
    .busy        (busy)
);

// File: tb/dac_frame_tx_bench.sv
module dac_frame_tx_bench;

    localparam int HALF = 2;
    localparam int SETUP = 3;
    localparam int GAP = 1;
    localparam int UPD = 2;
    localparam int LEAD = (HALF > SETUP) ? ((HALF > GAP) ? HALF : GAP) : ((SETUP > GAP) ? SETUP : GAP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dsp = 1'b0;
    logic [15:0] data = '0;
    logic valid_a = 1'b0, valid_m = 1'b0, req_a = 1'b0, req_m = 1'b0;
    logic rdy_a, sclk_a, fs_a, sd_a, upd_a, busy_a;
    logic rdy_m, sclk_m, fs_m, sd_m, upd_m, busy_m;
    logic sel = 1'b0;
    logic v_rdy, v_sclk, v_fs, v_sd, v_upd, v_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dac_frame_tx #(.SCLK_HALF_CYC(HALF), .SETUP_CYC(SETUP), .FS_GAP_CYC(GAP),
                   .UPDATE_LOW_CYC(UPD), .AUTO_UPDATE(1'b1)) u_dac_frame_tx (
        .clk(clk), .rst_n(rst_n), .dsp_framing(dsp), .in_valid(valid_a), .in_data(data),
        .in_ready(rdy_a), .load_req(req_a), .ser_clk(sclk_a), .frame_n(fs_a),
        .ser_data(sd_a), .update_n(upd_a), .busy(busy_a));

    dac_frame_tx #(.SCLK_HALF_CYC(HALF), .SETUP_CYC(SETUP), .FS_GAP_CYC(GAP),
                   .UPDATE_LOW_CYC(UPD), .AUTO_UPDATE(1'b0)) u_dac_frame_tx_manual (
        .clk(clk), .rst_n(rst_n), .dsp_framing(dsp), .in_valid(valid_m), .in_data(data),
        .in_ready(rdy_m), .load_req(req_m), .ser_clk(sclk_m), .frame_n(fs_m),
        .ser_data(sd_m), .update_n(upd_m), .busy(busy_m));

    assign v_rdy  = sel ? rdy_m  : rdy_a;
    assign v_sclk = sel ? sclk_m : sclk_a;
    assign v_fs   = sel ? fs_m   : fs_a;
    assign v_sd   = sel ? sd_m   : sd_a;
    assign v_upd  = sel ? upd_m  : upd_a;
    assign v_busy = sel ? busy_m : busy_a;

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic reset_state(input bit use_m);
        sel = use_m;
        @(negedge clk);
        check("R1 ser_clk idle", int'(v_sclk), 1);
        check("R1 frame_n idle", int'(v_fs), 1);
        check("R1 update_n idle", int'(v_upd), 1);
        check("R1 ser_data idle", int'(v_sd), 0);
        check("R1 busy idle", int'(v_busy), 0);
        check("R1 in_ready idle", int'(v_rdy), 1);
    endtask

    // Sends one word and measures the frame; req_mid pulses load_req mid-frame.
    task automatic send(input bit use_m, input logic [15:0] w, input bit req_mid);
        int fall_t[16];
        int n_fall = 0, fs_fall_t = -1, fs_rise_t = -1, end_rise_t = -1;
        int upd_start = -1, upd_len = 0, upd_pulses = 0, busy_low_t = -1;
        int pre_low = 0, spacing_bad = 0;
        bit fs_relow = 0, ready_bad = 0, prev_sclk = 1, prev_fs = 1, prev_upd = 1;
        logic [15:0] cap = '0;
        int first_t, last_t, exp_fs_rise, exp_end, total;
        string ftag;
        first_t = dsp ? 2 * LEAD : LEAD;
        last_t = first_t + 2 * HALF * 15;
        exp_end = last_t + HALF + 2 * GAP;
        exp_fs_rise = dsp ? (2 * LEAD + HALF) : (last_t + HALF + GAP);
        ftag = dsp ? "R6" : "R5";
        total = exp_end + UPD + 6;
        sel = use_m;
        @(negedge clk);
        data = w;
        if (use_m) valid_m = 1'b1; else valid_a = 1'b1;
        while (!v_rdy) @(negedge clk);
        @(negedge clk);
        valid_a = 1'b0;
        valid_m = 1'b0;
        check("R2 busy after accept", int'(v_busy), 1);
        for (int t = 0; t < total; t++) begin
            if (t > 0) @(negedge clk);
            if (fs_fall_t < 0 && !v_sclk) pre_low++;
            if (!v_fs && prev_fs && fs_fall_t < 0) fs_fall_t = t;
            if (!v_sclk && prev_sclk && fs_fall_t >= 0) begin
                if (n_fall < 16) fall_t[n_fall] = t;
                n_fall++;
                cap = {cap[14:0], v_sd};
            end
            if (v_fs && !prev_fs && n_fall > 0 && fs_rise_t < 0) fs_rise_t = t;
            if (fs_rise_t >= 0 && !v_fs) fs_relow = 1;
            if (v_sclk && !prev_sclk && n_fall == 16 && end_rise_t < 0) end_rise_t = t;
            if (!v_upd) begin
                if (prev_upd) begin
                    upd_pulses++;
                    upd_start = t;
                end
                upd_len++;
            end
            if (!v_busy && busy_low_t < 0) busy_low_t = t;
            if (v_busy && v_rdy) ready_bad = 1;
            prev_sclk = v_sclk;
            prev_fs = v_fs;
            prev_upd = v_upd;
            if (use_m) req_m = req_mid && (t == 10);
        end
        req_m = 1'b0;
        check("R3 captured word", int'(cap), int'(w));
        check("R3 fall count", n_fall, 16);
        for (int k = 0; k < 16; k++)
            if (k < n_fall && fall_t[k] != first_t + 2 * HALF * k) spacing_bad++;
        check("R4 fall spacing", spacing_bad, 0);
        check({ftag, " frame_n fall"}, fs_fall_t, dsp ? LEAD : 0);
        check({ftag, " frame_n rise"}, fs_rise_t, exp_fs_rise);
        check({ftag, " frame_n stays high"}, int'(fs_relow), 0);
        if (dsp) check("R6 clock parked before frame", pre_low, LEAD);
        check("R7 clock return", end_rise_t, exp_end);
        check("R2 ready while busy", int'(ready_bad), 0);
        check("R1 ser_data idle after frame", int'(v_sd), 0);
        if (!use_m) begin
            check("R8 strobe count", upd_pulses, 1);
            check("R8 strobe start", upd_start, exp_end);
            check("R8 strobe length", upd_len, UPD);
            check("R10 busy end", busy_low_t, exp_end + UPD);
        end else begin
            check("R9 strobe count", upd_pulses, req_mid ? 1 : 0);
            if (req_mid) begin
                check("R9 held request start", upd_start, exp_end + 1);
                check("R9 strobe length", upd_len, UPD);
            end
            check("R10 busy end", busy_low_t, exp_end);
        end
    endtask

    // Update request while idle.
    task automatic idle_request(input bit use_m);
        int pulses = 0, low = 0, start = -1;
        bit ready_low = 0, prev = 1;
        sel = use_m;
        @(negedge clk);
        if (use_m) req_m = 1'b1; else req_a = 1'b1;
        @(negedge clk);
        req_m = 1'b0;
        req_a = 1'b0;
        for (int t = 0; t < 10; t++) begin
            if (t > 0) @(negedge clk);
            if (!v_upd) begin
                if (prev) begin
                    pulses++;
                    start = t;
                end
                low++;
            end
            if (!v_rdy) ready_low = 1;
            prev = v_upd;
        end
        if (use_m) begin
            check("R9 idle request pulses", pulses, 1);
            check("R9 idle request start", start, 1);
            check("R9 idle request length", low, UPD);
            check("R9 ready held low", int'(ready_low), 1);
        end else begin
            check("R8 request ignored", pulses, 0);
            check("R8 ready unaffected", int'(ready_low), 0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        reset_state(1'b0);
        reset_state(1'b1);
        dsp = 1'b0;
        send(1'b0, 16'hA5C3, 1'b0);
        send(1'b0, 16'h8001, 1'b0);
        idle_request(1'b0);
        @(negedge clk);
        dsp = 1'b1;
        send(1'b0, 16'h7FFE, 1'b0);
        @(negedge clk);
        dsp = 1'b0;
        send(1'b1, 16'h1234, 1'b0);
        send(1'b1, 16'hFFFF, 1'b1);
        idle_request(1'b1);
        @(negedge clk);
        dsp = 1'b1;
        send(1'b1, 16'h0F0F, 1'b1);
        reset_state(1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule